// File: doc/BRIEF.md
# Bitstream Decimating Low-Pass FIR

This block is the digital filter of one receive channel. Once per clock enable it takes one bit of a sigma-delta modulator's pulse-density stream, with the enable running at half the master clock. It keeps the most recent 288 bits and, at every decimation boundary, forms a symmetric (linear-phase) low-pass FIR sum over them. The sum is rounded and saturated to a 12-bit two's-complement sample and issued with a one-cycle strobe. Each input bit selects whether its tap weight is added or subtracted, so no multipliers are needed. An I/Q receiver instantiates two copies.

A control state machine has three states. SLEEP holds the history cleared and issues nothing. FILL counts fresh samples after a reset or a wake-up. RUN means the whole history holds fresh data. The transitions are:
- any state to SLEEP while `sleep` is high;
- SLEEP to FILL on the first cycle `sleep` is low;
- FILL to RUN on the 288th accepted sample.

The `settled` output is high only in RUN. A configuration input chooses between two output rates.

Top module: `pdm_decim_fir`

## Requirements
- R1: While `rst_n` is low, `out_stb` and `settled` are 0 and `out_data` is 0; reset leaves the block in FILL with a cleared (all-zero) history and a decimation phase of 0.
- R2: A sample is accepted on a rising edge where `ce` is high, `sleep` is low and the block is not in SLEEP; the accepted bit enters the 288-bit history, and the oldest bit leaves it.
- R3: Each issued sample is computed over the history including the bit accepted at that edge. A bit of 1 counts +1 and a bit of 0 counts -1. Tap k (0 to 287) has weight min(k+1, 288-k). If acc is the signed weighted sum, the result is floor((acc+4)/8).
- R4: The result is saturated to the range -2048..2047; 288 ones give 2047 and 288 zeros give -2048.
- R5: With `rate_fast`=0, every 24th accepted sample is a decimation boundary; with `rate_fast`=1, every 12th. `out_stb` is high for exactly the one cycle after a boundary edge, and `out_data` changes only then.
- R6: On an edge where `sleep` is high, the history is cleared and the phase is reset to 0. Afterwards `out_stb` and `settled` stay 0 until wake-up, and input bits offered meanwhile have no effect.
- R7: `settled` rises at the edge that accepts the 288th sample after reset or wake-up, and it stays high until the next sleep.
- R8: The first edge with `sleep` low after SLEEP only moves the block to FILL; no bit is accepted on that edge.
- R9: The accumulator holds every sum in the range ±20880 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Input bit enable, half the master clock rate |
| din | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| rate_fast | input | 1 | 0: decimate by 24, 1: decimate by 12 |
| sleep | input | 1 | Synchronous standby request; clears history |
| out_data | output | 12 | Filtered sample, two's complement |
| out_stb | output | 1 | One-cycle strobe marking a new `out_data` |
| settled | output | 1 | High once 288 fresh samples have been taken |

## Verification
`out_stb` and the new `out_data` appear one cycle after the enable edge that completes a decimation period. `settled` changes at the same edge as the 288th accepted sample after reset or wake-up. A sleep request takes effect at the next edge, and the wake-up edge itself consumes no bit. The bench drives inputs and samples outputs on falling edges. A behavioural model is updated on each rising edge, so every comparison made at the following falling edge sees the registered result of that edge. Directed checks of saturation values and strobe counts are taken two falling edges after the last stimulus, so the last strobe has already appeared.

// File: rtl/pdm_fir_pkg.sv
package pdm_fir_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2
    } fir_state_e;

    // Symmetric triangular tap weight: linear phase, low-pass.
    function automatic int tap_weight(input int k, input int taps);
        return ((k + 1) < (taps - k)) ? (k + 1) : (taps - k);
    endfunction

    function automatic int weight_total(input int taps);
        int s;
        s = 0;
        for (int i = 0; i < taps; i++) s += tap_weight(i, taps);
        return s;
    endfunction

endpackage

// File: rtl/pdm_fir_ctrl.sv
module pdm_fir_ctrl
    import pdm_fir_pkg::*;
#(
    parameter int TAPS     = 288,
    parameter int DEC_SLOW = 24,
    parameter int DEC_FAST = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sleep,
    input  logic rate_fast,
    output logic accept,
    output logic boundary,
    output logic hist_clr,
    output logic settled
);

    localparam int CNT_W   = $clog2(TAPS + 1);
    localparam int DEC_MAX = (DEC_SLOW > DEC_FAST) ? DEC_SLOW : DEC_FAST;
    localparam int PH_W    = $clog2(DEC_MAX + 1);

    fir_state_e       state_q, state_d;
    logic [CNT_W-1:0] fill_q;
    logic [PH_W-1:0]  phase_q;
    logic [PH_W-1:0]  dec_last;

    assign accept   = ce && !sleep && (state_q != ST_SLEEP);
    assign dec_last = rate_fast ? PH_W'(DEC_FAST - 1) : PH_W'(DEC_SLOW - 1);
    assign boundary = accept && (phase_q >= dec_last);
    assign hist_clr = sleep;
    assign settled  = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: if (!sleep) state_d = ST_FILL;
            ST_FILL: begin
                if (sleep)                                      state_d = ST_SLEEP;
                else if (accept && fill_q == CNT_W'(TAPS - 1))  state_d = ST_RUN;
            end
            ST_RUN:   if (sleep) state_d = ST_SLEEP;
            default:  state_d = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q  <= '0;
            phase_q <= '0;
        end else if (sleep) begin
            fill_q  <= '0;
            phase_q <= '0;
        end else if (accept) begin
            phase_q <= boundary ? '0 : phase_q + 1'b1;
            if (state_q == ST_FILL) fill_q <= fill_q + 1'b1;
        end
    end

    // R7: the fill counter never runs past the tap count while filling
    p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (fill_q < CNT_W'(TAPS)));

    // R8: entering FILL from SLEEP starts with an empty fill count
    p_wake_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SLEEP && state_q == ST_FILL) |-> (fill_q == '0));

endmodule

// File: rtl/pdm_fir_hist.sv
module pdm_fir_hist #(
    parameter int TAPS = 288
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift,
    input  logic            din,
    output logic [TAPS-1:0] hist
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist <= '0;
        else if (clr)   hist <= '0;
        else if (shift) hist <= {hist[TAPS-2:0], din};
    end

endmodule

// File: rtl/pdm_fir_mac.sv
module pdm_fir_mac
    import pdm_fir_pkg::*;
#(
    parameter int TAPS  = 288,
    parameter int OUT_W = 12,
    parameter int SHIFT = 3,
    parameter int ACC_W = 18
) (
    input  logic [TAPS-1:0]          taps,
    output logic signed [ACC_W-1:0]  acc,
    output logic signed [OUT_W-1:0]  sample
);

    localparam logic signed [ACC_W-1:0] HI   = ACC_W'((1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO   = -HI - 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 <<< (SHIFT - 1));

    logic signed [ACC_W-1:0] acc_v;
    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] shv;

    // Each bit adds (1) or subtracts (0) its tap weight.
    always_comb begin
        acc_v = '0;
        for (int k = 0; k < TAPS; k++) begin
            if (taps[k]) acc_v = acc_v + ACC_W'(tap_weight(k, TAPS));
            else         acc_v = acc_v - ACC_W'(tap_weight(k, TAPS));
        end
        acc = acc_v;
    end

    always_comb begin
        rnd = acc + HALF;
        shv = rnd >>> SHIFT;
        if (shv > HI)      sample = HI[OUT_W-1:0];
        else if (shv < LO) sample = LO[OUT_W-1:0];
        else               sample = shv[OUT_W-1:0];
    end

endmodule

// File: rtl/pdm_decim_fir.sv
module pdm_decim_fir
    import pdm_fir_pkg::*;
#(
    parameter int TAPS     = 288,
    parameter int OUT_W    = 12,
    parameter int DEC_SLOW = 24,
    parameter int DEC_FAST = 12,
    parameter int SHIFT    = 3,
    parameter int ACC_W    = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             din,
    input  logic             rate_fast,
    input  logic             sleep,
    output logic [OUT_W-1:0] out_data,
    output logic             out_stb,
    output logic             settled
);

    localparam int WSUM = weight_total(TAPS);

    logic                    accept, boundary, hist_clr;
    logic [TAPS-1:0]         hist_q;
    logic [TAPS-1:0]         hist_nxt;
    logic signed [ACC_W-1:0] acc;
    logic signed [OUT_W-1:0] sample;

    pdm_fir_ctrl #(.TAPS(TAPS), .DEC_SLOW(DEC_SLOW), .DEC_FAST(DEC_FAST)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .sleep     (sleep),
        .rate_fast (rate_fast),
        .accept    (accept),
        .boundary  (boundary),
        .hist_clr  (hist_clr),
        .settled   (settled)
    );

    pdm_fir_hist #(.TAPS(TAPS)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hist_clr),
        .shift (accept),
        .din   (din),
        .hist  (hist_q)
    );

    // The sum includes the bit accepted at the boundary edge.
    assign hist_nxt = {hist_q[TAPS-2:0], din};

    pdm_fir_mac #(.TAPS(TAPS), .OUT_W(OUT_W), .SHIFT(SHIFT), .ACC_W(ACC_W)) u_mac (
        .taps   (hist_nxt),
        .acc    (acc),
        .sample (sample)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_stb  <= 1'b0;
            out_data <= '0;
        end else begin
            out_stb <= boundary;
            if (boundary) out_data <= sample;
        end
    end

    // R5: a strobe always follows an enabled input edge
    p_stb_after_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(ce));

    // R6: a sleep request silences strobe and settled at the next edge
    p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> (!out_stb && !settled));

    // R7: settled only rises on an edge that took an input bit
    p_settle_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> $past(ce));

    // R9: the accumulator stays inside the weight total, so it never wraps
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> (acc <= ACC_W'(WSUM) && acc >= -ACC_W'(WSUM)));

endmodule

// File: tb/test_pdm_decim_fir.sv
module test_pdm_decim_fir;

    localparam int NT = 288;

    logic        clk = 1'b0;
    logic        rst_n, ce, din, rate_fast, sleep;
    logic [11:0] out_data;
    logic        out_stb, settled;

    always #4 clk = ~clk;

    pdm_decim_fir i_pdm_decim_fir (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .rate_fast(rate_fast),
        .sleep(sleep), .out_data(out_data), .out_stb(out_stb), .settled(settled)
    );

    int checks = 0;
    int fails  = 0;
    int stb_seen = 0;
    logic [15:0] lf = 16'hACE1;

    // behavioural reference model
    bit mq[$];
    int m_ph, m_cnt, m_data;
    bit m_asleep, m_stb, m_settled, m_live;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_out();
        int acc, w, y;
        acc = 0;
        foreach (mq[k]) begin
            w = ((k + 1) < (NT - k)) ? (k + 1) : (NT - k);
            acc += mq[k] ? w : -w;
        end
        y = (acc + 4) >>> 3;
        if (y > 2047)  y = 2047;
        if (y < -2048) y = -2048;
        return y;
    endfunction

    task automatic model_clear();
        mq.delete();
        for (int i = 0; i < NT; i++) mq.push_back(1'b0);
        m_ph = 0; m_cnt = 0; m_stb = 0; m_settled = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
            m_asleep = 0; m_data = 0; m_live = 1;
        end else if (sleep) begin
            model_clear();
            m_asleep = 1;
        end else if (m_asleep) begin
            m_asleep = 0;            // wake edge takes no bit (R8)
            m_stb = 0;
        end else if (ce) begin
            int dec;
            dec = rate_fast ? 12 : 24;
            mq.push_front(din);
            void'(mq.pop_back());
            m_stb = (m_ph >= dec - 1);
            m_ph  = m_stb ? 0 : m_ph + 1;
            if (m_stb) m_data = model_out();
            if (!m_settled) begin
                m_cnt++;
                if (m_cnt == NT) m_settled = 1;
            end
        end else begin
            m_stb = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live) begin
            check(out_stb == m_stb, "R5 strobe timing", out_stb, m_stb);
            check(settled == m_settled, "R7 settled flag", settled, m_settled);
            if (m_stb) check($signed(out_data) == m_data, "R3 sample value", $signed(out_data), m_data);
            if (out_stb) stb_seen++;
        end
    end

    function automatic bit pick(input int mode, input int idx);
        case (mode)
            0: return lf[0];
            1: return 1'b1;
            2: return 1'b0;
            default: return idx[0];
        endcase
    endfunction

    task automatic drive(input int n, input int mode, input int gap);
        for (int s = 0; s < n; s++) begin
            for (int g = 0; g < gap - 1; g++) begin
                @(negedge clk); ce = 1'b0;
            end
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ce = 1'b1; din = pick(mode, s);
        end
        @(negedge clk); ce = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic nap(input bit fast);
        @(negedge clk); sleep = 1'b1; ce = 1'b1; din = 1'b1;   // offered bits ignored (R6)
        repeat (4) @(negedge clk);
        rate_fast = fast;
        check(settled == 1'b0 && out_stb == 1'b0, "R6 quiet while asleep", settled, 0);
        @(negedge clk); sleep = 1'b0; ce = 1'b1; din = 1'b1;   // wake edge (R8)
        @(negedge clk); ce = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        m_live = 0;
        rst_n = 1'b0; ce = 1'b0; din = 1'b0; rate_fast = 1'b0; sleep = 1'b0;
        repeat (3) @(negedge clk);
        check(out_stb == 1'b0, "R1 reset strobe", out_stb, 0);
        check(settled == 1'b0, "R1 reset settled", settled, 0);
        check(out_data == 12'd0, "R1 reset data", out_data, 0);
        rst_n = 1'b1;

        drive(400, 0, 2);                              // R2 random stream
        check(settled == 1'b1, "R7 settled after fill", settled, 1);
        drive(330, 1, 2);
        check($signed(out_data) == 2047, "R4 positive saturation", $signed(out_data), 2047);
        drive(330, 2, 1);
        check($signed(out_data) == -2048, "R4 negative saturation", $signed(out_data), -2048);

        nap(1'b1);
        drive(100, 3, 1);                              // alternating in fast mode
        check(settled == 1'b0, "R7 not settled after 100", settled, 0);
        drive(200, 0, 3);
        check(settled == 1'b1, "R7 settled after 300", settled, 1);

        nap(1'b0);
        stb_seen = 0;
        drive(240, 0, 2);
        check(stb_seen == 10, "R5 slow decimation count", stb_seen, 10);

        nap(1'b1);
        stb_seen = 0;
        drive(240, 0, 1);
        check(stb_seen == 20, "R5 fast decimation count", stb_seen, 20);

        nap(1'b0);                                     // sleep during fill
        drive(50, 0, 1);
        check(settled == 1'b0, "R6 refill restarted", settled, 0);
        drive(330, 1, 2);
        check($signed(out_data) == 2047, "R9 full scale no wrap", $signed(out_data), 2047);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule